// File: doc/BRIEF.md
# Configurable Synchronous Serial Receiver

This block is the receive half of a synchronous serial port. It watches a serial clock, a serial data line and a frame sync line, all sampled in the system clock domain. It collects each data word bit by bit and presents it right-justified on a parallel output with a one-cycle valid strobe. The word length, the bit order, the output format and all frame sync behaviour are set by static configuration inputs. The frame sync rules cover its source, polarity, early or late timing, whether every word needs its own sync, and which serial clock edge samples data.

A frame sync can come from the pin or from an internal generator. The generator emits a one-serial-clock pulse every `cfg_fs_period` serial clocks, and that pulse is also visible on `fs_out`. Companded formats are not expanded; the code is delivered zero-filled. A word that completes while the previous one is still unread raises a sticky overrun flag. Configuration is expected to change only while the block is held in reset.

Top module: `serial_rx`

## Requirements
- R1: A word holds `cfg_len`+1 bits (legal `cfg_len` values 2 to 15, giving 3 to 16 bits), and `rx_data` carries it right-justified in bits [`cfg_len`:0].
- R2: `cfg_lsb_first`=0 receives the most significant bit first; `cfg_lsb_first`=1 receives the least significant bit first.
- R3: `cfg_dtype` 2'b01 copies bit `cfg_len` into all higher bits of `rx_data`. 2'b00, 2'b10 and 2'b11 fill the higher bits with zero and pass the received code unchanged.
- R4: With `cfg_late`=0, the first data bit is taken on the sampling edge after the one on which the frame sync is seen. With `cfg_late`=1, the first data bit is taken on the same edge as the frame sync.
- R5: `cfg_fs_low`=1 makes the frame sync active low, on `fs_in` and on `fs_out`; `cfg_fs_low`=0 makes it active high.
- R6: `cfg_rise_edge`=1 samples data and external frame sync on the rising `sclk` edge and drives the internal sync on the falling edge. `cfg_rise_edge`=0 swaps the two edges.
- R7: With `cfg_fs_every`=1, each word needs its own frame sync, and bits arriving without one produce no word. With `cfg_fs_every`=0, one sync starts an unbroken stream of back-to-back words.
- R8: With `cfg_int_fs`=1, the receiver uses an internal sync that is active for one serial clock in every `cfg_fs_period` serial clocks and is shown on `fs_out`. With `cfg_int_fs`=0, `fs_out` rests at its inactive level.
- R9: `rx_valid` is high for exactly one system clock per completed word.
- R10: `rx_overrun` sets when a word completes while the previous word has not been acknowledged by `rd_ack`. It stays set until `ovr_clr`, which has priority.
- R11: After reset, `rx_data` is 0 and `rx_valid`, `rx_overrun` and `fs_out` (active-high setting) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| din | input | 1 | Serial data |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Internal frame sync, polarity applied |
| cfg_len | input | 4 | Word length minus one |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_dtype | input | 2 | Output format select |
| cfg_int_fs | input | 1 | 1: internal frame sync |
| cfg_fs_every | input | 1 | 1: sync required for each word |
| cfg_fs_low | input | 1 | 1: active-low frame sync |
| cfg_late | input | 1 | 1: late frame sync |
| cfg_rise_edge | input | 1 | 1: sample on rising sclk edge |
| cfg_fs_period | input | 8 | Internal sync period in serial clocks |
| rd_ack | input | 1 | Host has taken the current word |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 16 | Received, formatted word |
| rx_valid | output | 1 | One-cycle word strobe |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is word alignment under the internal frame sync. The bench cannot choose when the sync fires; it can only see it on `fs_out`. So the stimulus watches that pin in each serial period and starts shifting the word on the next period. Doing the same thing for several frames also measures the sync spacing in serial clocks. Back-to-back streaming needs its own setup: a reset before the test, because once started the stream never stops. A second word with no sync of its own, under the required-sync policy, shows that the unsynced bits are dropped.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int DATA_W = 16;
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int CNT_W  = LEN_W + 1;

    typedef enum logic [1:0] {
        FMT_ZERO  = 2'b00,
        FMT_SIGN  = 2'b01,
        FMT_CODE1 = 2'b10,
        FMT_CODE2 = 2'b11
    } fmt_e;
endpackage

// File: rtl/sclk_edge.sv
module sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic rise_sel,
    output logic smp_stb,
    output logic drv_stb
);
    typedef struct packed {
        logic sclk;
    } st_t;

    st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        rise      = sclk & ~st_q.sclk;
        fall      = ~sclk & st_q.sclk;
        smp_stb   = rise_sel ? rise : fall;
        drv_stb   = rise_sel ? fall : rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fs_gen.sv
module fs_gen #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             drv_stb,
    input  logic [PER_W-1:0] period,
    output logic             fs_int
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             fs;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else if (drv_stb) begin
            st_d.fs = (st_q.cnt == '0);
            if (period <= PER_W'(1) || st_q.cnt >= period - PER_W'(1))
                st_d.cnt = '0;
            else
                st_d.cnt = st_q.cnt + PER_W'(1);
        end
        fs_int = st_q.fs;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rx_shift.sv
module rx_shift
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              din,
    input  logic              fs_act,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              lsb_first,
    input  logic              late,
    input  logic              fs_every,
    input  logic [1:0]        dtype,
    output logic              done,
    output logic [DATA_W-1:0] word
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  nb;
        logic [DATA_W-1:0] sh;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0]  wlen, base, nbn;
    logic [DATA_W-1:0] raw;
    logic              take, sgn;

    always_comb begin
        st_d = st_q;
        wlen = {1'b0, cfg_len} + CNT_W'(1);
        take = 1'b0;
        done = 1'b0;
        base = st_q.busy ? st_q.nb : '0;
        nbn  = base + CNT_W'(1);
        if (smp_stb) begin
            if (st_q.busy) begin
                take = 1'b1;
            end else if (fs_act) begin
                st_d.busy = 1'b1;
                st_d.nb   = '0;
                take      = late;
            end
        end
        if (take) begin
            st_d.sh = lsb_first ? {din, st_q.sh[DATA_W-1:1]}
                                : {st_q.sh[DATA_W-2:0], din};
            if (nbn == wlen) begin
                done      = 1'b1;
                st_d.nb   = '0;
                st_d.busy = !fs_every || (fs_act && !late);
            end else begin
                st_d.nb   = nbn;
                st_d.busy = 1'b1;
            end
        end
        raw = lsb_first ? (st_d.sh >> (DATA_W - int'(wlen))) : st_d.sh;
        sgn = raw[cfg_len];
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < wlen) word[i] = raw[i];
            else                  word[i] = (fmt_e'(dtype) == FMT_SIGN) ? sgn : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import serial_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        din,
    input  logic        fs_in,
    output logic        fs_out,
    input  logic [3:0]  cfg_len,
    input  logic        cfg_lsb_first,
    input  logic [1:0]  cfg_dtype,
    input  logic        cfg_int_fs,
    input  logic        cfg_fs_every,
    input  logic        cfg_fs_low,
    input  logic        cfg_late,
    input  logic        cfg_rise_edge,
    input  logic [7:0]  cfg_fs_period,
    input  logic        rd_ack,
    input  logic        ovr_clr,
    output logic [15:0] rx_data,
    output logic        rx_valid,
    output logic        rx_overrun
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              pend;
        logic              ovr;
    } st_t;

    st_t st_d, st_q;
    logic smp_stb, drv_stb, fs_int, fs_act, done;
    logic [DATA_W-1:0] word;

    sclk_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise_sel(cfg_rise_edge),
        .smp_stb(smp_stb), .drv_stb(drv_stb)
    );

    fs_gen #(.PER_W(8)) u_fsg (
        .clk(clk), .rst_n(rst_n), .enable(cfg_int_fs), .drv_stb(drv_stb),
        .period(cfg_fs_period), .fs_int(fs_int)
    );

    assign fs_act = cfg_int_fs ? fs_int : (fs_in ^ cfg_fs_low);

    rx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .din(din), .fs_act(fs_act),
        .cfg_len(cfg_len), .lsb_first(cfg_lsb_first), .late(cfg_late),
        .fs_every(cfg_fs_every), .dtype(cfg_dtype), .done(done), .word(word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = done;
        if (done) begin
            st_d.data = word;
            st_d.pend = 1'b1;
        end else if (rd_ack) begin
            st_d.pend = 1'b0;
        end
        if (ovr_clr)                              st_d.ovr = 1'b0;
        else if (done && st_q.pend && !rd_ack)    st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data    = st_q.data;
    assign rx_valid   = st_q.valid;
    assign rx_overrun = st_q.ovr;
    assign fs_out     = fs_int ^ cfg_fs_low;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cfg_len,
    input logic [1:0]  cfg_dtype,
    input logic        cfg_int_fs,
    input logic        cfg_fs_low,
    input logic        fs_out,
    input logic        ovr_clr,
    input logic [15:0] rx_data,
    input logic        rx_valid,
    input logic        rx_overrun
);
    logic [15:0] ashift;
    assign ashift = 16'($signed(rx_data) >>> cfg_len);

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);

    assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr |=> !rx_overrun);

    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_dtype != 2'b01) |-> ((rx_data >> ({1'b0, cfg_len} + 5'd1)) == 16'd0));

    assert_sign_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_dtype == 2'b01) |-> (ashift == 16'd0 || ashift == 16'hFFFF));

    assert_fs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_int_fs |-> (fs_out == cfg_fs_low));
endmodule

bind serial_rx serial_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_dtype(cfg_dtype),
    .cfg_int_fs(cfg_int_fs), .cfg_fs_low(cfg_fs_low), .fs_out(fs_out),
    .ovr_clr(ovr_clr), .rx_data(rx_data), .rx_valid(rx_valid), .rx_overrun(rx_overrun)
);

// File: tb/sim_serial_rx.sv
`timescale 1ns/1ps
module sim_serial_rx;
    logic clk = 0, rst_n = 0, sclk = 0, din = 0, fs_in = 0;
    logic [3:0] cfg_len = 4'd7;
    logic cfg_lsb_first = 0, cfg_int_fs = 0, cfg_fs_every = 1, cfg_fs_low = 0;
    logic cfg_late = 0, cfg_rise_edge = 1;
    logic [1:0] cfg_dtype = 0;
    logic [7:0] cfg_fs_period = 8'd10;
    logic rd_ack = 0, ovr_clr = 0;
    logic fs_out, rx_valid, rx_overrun;
    logic [15:0] rx_data;

    int checks = 0, fails = 0;
    logic [15:0] got[$];
    bit finished = 0;

    always #4 clk = ~clk;

    serial_rx u0 (.*);

    always @(negedge clk) if (rx_valid) got.push_back(rx_data);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        sclk = cfg_rise_edge ? 1'b0 : 1'b1;
        fs_in = cfg_fs_low; din = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        got.delete();
        @(negedge clk);
    endtask

    task automatic period(logic d, logic f_active);
        sclk = cfg_rise_edge ? 1'b0 : 1'b1;
        din = d; fs_in = f_active ^ cfg_fs_low;
        repeat (4) @(negedge clk);
        sclk = cfg_rise_edge ? 1'b1 : 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic bitat(logic [15:0] w, int i, int l);
        return cfg_lsb_first ? w[i] : w[l-1-i];
    endfunction

    task automatic send_word(logic [15:0] w, bit with_fs);
        int l = int'(cfg_len) + 1;
        if (with_fs && !cfg_late) period(1'b0, 1'b1);
        for (int i = 0; i < l; i++) period(bitat(w, i, l), with_fs && cfg_late && i == 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) period(1'b0, 1'b0);
    endtask

    task automatic expect_one(string req, logic [15:0] exp);
        chk({req, " count"}, got.size(), 1);
        if (got.size() > 0) chk(req, got[0], exp);
        got.delete();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 data", rx_data, 0);
        chk("R11 valid", rx_valid, 0);
        chk("R11 overrun", rx_overrun, 0);
        chk("R11 fs_out", fs_out, 0);
    endtask

    task automatic t_msb8();
        cfg_len = 7; cfg_dtype = 0; cfg_lsb_first = 0; do_reset();
        send_word(16'h00A5, 1); idle(2);
        expect_one("R1 R2 msb 8-bit", 16'h00A5);
    endtask

    task automatic t_lsb12();
        cfg_len = 11; cfg_lsb_first = 1; do_reset();
        send_word(16'h09C3, 1); idle(2);
        expect_one("R2 lsb 12-bit", 16'h09C3);
        cfg_lsb_first = 0;
    endtask

    task automatic t_sign();
        cfg_len = 4; cfg_dtype = 2'b01; do_reset();
        send_word(16'h0016, 1); idle(2);
        expect_one("R3 sign negative", 16'hFFF6);
        send_word(16'h000B, 1); idle(2);
        expect_one("R3 sign positive", 16'h000B);
        cfg_dtype = 2'b10; cfg_len = 7; do_reset();
        send_word(16'h0081, 1); idle(2);
        expect_one("R3 code pass-through", 16'h0081);
        cfg_dtype = 0;
    endtask

    task automatic t_late();
        cfg_len = 7; cfg_late = 1; do_reset();
        send_word(16'h003C, 1); idle(2);
        expect_one("R4 late sync", 16'h003C);
        cfg_late = 0; do_reset();
        period(1'b1, 1'b1);
        send_word(16'h005A, 0); idle(2);
        expect_one("R4 early skips sync bit", 16'h005A);
    endtask

    task automatic t_low_fall();
        cfg_len = 9; cfg_fs_low = 1; cfg_rise_edge = 0; do_reset();
        chk("R5 fs_out idle low-active", fs_out, 1);
        send_word(16'h0273, 1); idle(2);
        expect_one("R5 R6 low sync falling edge", 16'h0273);
        cfg_fs_low = 0; cfg_rise_edge = 1;
    endtask

    task automatic t_required();
        cfg_len = 7; cfg_fs_every = 1; do_reset();
        send_word(16'h0011, 1);
        send_word(16'h00EE, 0); idle(2);
        expect_one("R7 unsynced word dropped", 16'h0011);
        cfg_fs_every = 0; do_reset();
        send_word(16'h0012, 1);
        send_word(16'h0034, 0);
        chk("R7 stream count", got.size(), 2);
        if (got.size() == 2) begin
            chk("R7 stream word0", got[0], 16'h0012);
            chk("R7 stream word1", got[1], 16'h0034);
        end
        cfg_fs_every = 1;
    endtask

    task automatic t_internal();
        int last = -1, bi = -1, frames = 0;
        logic [15:0] w = 16'h00C6;
        cfg_len = 7; cfg_int_fs = 1; cfg_fs_period = 10; do_reset();
        for (int p = 0; p < 45; p++) begin
            sclk = 0;
            repeat (2) @(negedge clk);
            din = 0;
            if (fs_out) begin
                if (last >= 0) chk("R8 sync spacing", p - last, 10);
                last = p; bi = 0; frames++;
            end else if (bi >= 0 && bi < 8) begin
                din = w[7-bi]; bi++;
            end
            repeat (2) @(negedge clk);
            sclk = 1;
            repeat (4) @(negedge clk);
        end
        chk("R8 frames seen", (frames >= 3), 1);
        chk("R8 words", (got.size() >= frames - 1), 1);
        foreach (got[i]) chk("R8 internal word", got[i], 16'h00C6);
        cfg_int_fs = 0;
    endtask

    task automatic t_overrun();
        cfg_len = 15; do_reset();
        send_word(16'hBEEF, 1); idle(1);
        chk("R9 full width", got.size() > 0 ? got[0] : 16'h0, 16'hBEEF);
        chk("R10 no overrun first", rx_overrun, 0);
        send_word(16'h1234, 1); idle(1);
        chk("R10 overrun set", rx_overrun, 1);
        idle(2);
        chk("R10 overrun held", rx_overrun, 1);
        ovr_clr = 1; @(negedge clk); ovr_clr = 0; @(negedge clk);
        chk("R10 overrun cleared", rx_overrun, 0);
        rd_ack = 1; @(negedge clk); rd_ack = 0;
        send_word(16'h0F0F, 1); idle(1);
        chk("R10 acked no overrun", rx_overrun, 0);
        chk("R9 one strobe per word", got.size(), 3);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_msb8();
        t_lsb12();
        t_sign();
        t_late();
        t_low_fall();
        t_required();
        t_internal();
        t_overrun();
        finished = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            summary();
        end
    end
endmodule